// File: doc/BRIEF.md
# Keyboard Controller Power-State Sequencer

This block decides when the execution core of a small embedded keyboard controller may run. It controls three enables. The first gates the execution-unit clock. The second gates the clock for the timer/counter and interrupt logic. The third drives the oscillator enable. Two sleep depths are supported:

- A halt request selects a light sleep. Only the execution clock stops, so timers and interrupts keep working.
- A stop request selects a deep sleep. Everything stops, including the oscillator.

A byte written by the host into the input buffer wakes the core from either depth, and so does a core reset. After a deep sleep, a host-write wake holds the core for a programmable number of clock cycles while the oscillator settles.

On every return to execution, the block emits a one-cycle resume-action code that tells the core what to do next. If a host write woke the core and the input-buffer-full interrupt is enabled, the core calls the interrupt routine. If the interrupt is disabled, the core continues with the next instruction. After a reset, the core restarts from address 0. The block itself runs from an always-on reference clock. Every input is a plain level or pulse sampled on that clock, so there is no streamed data and no back-pressure.

Top module: `sleep_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in the running state: `exec_clk_en`, `tmr_clk_en` and `osc_en` are 1, `act_valid` is 0 and `act_code` is 0.
- R2: A `halt_req` sampled while running enters light sleep on the next cycle: `exec_clk_en`=0, `tmr_clk_en`=1, `osc_en`=1.
- R3: A `stop_req` sampled while running enters deep sleep on the next cycle: all three enables are 0. When `stop_req` and `halt_req` arrive in the same cycle, `stop_req` wins.
- R4: `halt_req` and `stop_req` have no effect while asleep, settling or held in reset.
- R5: A `host_wr` in light sleep returns to running on the next cycle with a one-cycle action pulse. The code is 1 (call interrupt routine) if `ibf_irq_en` was 1 in the write cycle, else 2 (continue).
- R6: A `host_wr` in deep sleep raises `osc_en` on the next cycle. `exec_clk_en` and `tmr_clk_en` then stay 0 for `settle_cycles` cycles, after which the block runs with the action pulse. The code comes from `ibf_irq_en` as sampled in the write cycle. When `settle_cycles`=0, running resumes on the cycle right after the write.
- R7: A `host_wr` while running or while settling has no effect and produces no action pulse.
- R8: A `core_rst` sampled in any state gives, on the next cycle: `exec_clk_en`=0, `tmr_clk_en`=1, `osc_en`=1 and no action pulse. This state holds while `core_rst` stays high, and `core_rst` takes priority over a `host_wr` in the same cycle.
- R9: The cycle after `core_rst` falls, the block runs and pulses action code 3 (restart at address 0).
- R10: `act_valid` is never high for two cycles in a row. `act_code` is 0 whenever `act_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low block reset |
| halt_req | input | 1 | Request for light sleep |
| stop_req | input | 1 | Request for deep sleep |
| host_wr | input | 1 | Host wrote a byte into the input buffer |
| ibf_irq_en | input | 1 | Input-buffer-full interrupt enabled |
| core_rst | input | 1 | Core reset, level, active high |
| settle_cycles | input | SETTLE_W | Oscillator settle wait after a deep-sleep host wake |
| exec_clk_en | output | 1 | Execution-unit clock enable |
| tmr_clk_en | output | 1 | Timer/counter and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| act_valid | output | 1 | One-cycle resume-action strobe |
| act_code | output | 2 | Resume action: 1 vector, 2 continue, 3 restart, 0 none |

## Verification
On every cycle, the checker asserts the following:
- no clock enable is on while the oscillator is off;
- an action pulse only occurs while running and never repeats;
- the code is zero between pulses;
- a reset always leads to the hold state and then to a restart pulse.

Some behaviours only the bench scenarios can show:
- the length of the settle wait for several counts, including zero;
- the choice between the vector code and the continue code, and the cycle in which the interrupt enable is sampled;
- stop winning over halt;
- requests and host writes being ignored in the states where they must be.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SOFT   = 3'd1,
    ST_HARD   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_RESET  = 3'd4
  } psq_state_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_VECTOR   = 2'd1,
    ACT_CONTINUE = 2'd2,
    ACT_RESTART  = 2'd3
  } psq_act_e;

endpackage

// File: rtl/psq_wake_arb.sv
module psq_wake_arb
  import psq_pkg::*;
(
  input  psq_state_e state,
  input  logic       core_rst,
  input  logic       host_wr,
  input  logic       ibf_irq_en,
  output logic       rst_take,
  output logic       host_take,
  output psq_act_e   host_act
);

  logic asleep;

  always_comb begin
    asleep    = (state == ST_SOFT) || (state == ST_HARD);
    rst_take  = core_rst;
    // reset wins over a host write in the same cycle
    host_take = host_wr && !core_rst && asleep;
    host_act  = ibf_irq_en ? ACT_VECTOR : ACT_CONTINUE;
  end

endmodule

// File: rtl/psq_settle_timer.sv
module psq_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  input  logic                tick,
  output logic                load_zero,
  output logic                done
);

  localparam logic [SETTLE_W-1:0] ONE = SETTLE_W'(1);

  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign load_zero = (load_val == '0);
  assign done      = (cnt_q <= ONE);

endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       rst_take,
  input  logic       host_take,
  input  psq_act_e   host_act,
  input  logic       load_zero,
  input  logic       tmr_done,
  output psq_state_e state,
  output logic       tmr_load,
  output logic       tmr_tick,
  output logic       exec_clk_en,
  output logic       tmr_clk_en,
  output logic       osc_en,
  output psq_act_e   act
);

  psq_state_e state_q, state_n;
  psq_act_e   act_q, act_n;
  psq_act_e   pend_q;

  always_comb begin
    state_n  = state_q;
    act_n    = ACT_NONE;
    tmr_load = 1'b0;
    if (rst_take) begin
      state_n = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (stop_req)      state_n = ST_HARD;
          else if (halt_req) state_n = ST_SOFT;
        end
        ST_SOFT: begin
          if (host_take) begin
            state_n = ST_RUN;
            act_n   = host_act;
          end
        end
        ST_HARD: begin
          if (host_take) begin
            if (load_zero) begin
              state_n = ST_RUN;
              act_n   = host_act;
            end else begin
              state_n  = ST_SETTLE;
              tmr_load = 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (tmr_done) begin
            state_n = ST_RUN;
            act_n   = pend_q;
          end
        end
        ST_RESET: begin
          state_n = ST_RUN;
          act_n   = ACT_RESTART;
        end
        default: state_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      act_q   <= ACT_NONE;
      pend_q  <= ACT_CONTINUE;
    end else begin
      state_q <= state_n;
      act_q   <= act_n;
      if (tmr_load) pend_q <= host_act;
    end
  end

  assign state       = state_q;
  assign tmr_tick    = (state_q == ST_SETTLE);
  assign exec_clk_en = (state_q == ST_RUN);
  assign tmr_clk_en  = (state_q == ST_RUN) || (state_q == ST_SOFT) || (state_q == ST_RESET);
  assign osc_en      = (state_q != ST_HARD);
  assign act         = act_q;

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import psq_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                stop_req,
  input  logic                host_wr,
  input  logic                ibf_irq_en,
  input  logic                core_rst,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                exec_clk_en,
  output logic                tmr_clk_en,
  output logic                osc_en,
  output logic                act_valid,
  output logic [1:0]          act_code
);

  psq_state_e state;
  psq_act_e   host_act, act;
  logic       rst_take, host_take;
  logic       tmr_load, tmr_tick, load_zero, tmr_done;

  psq_wake_arb i_arb (
    .state      (state),
    .core_rst   (core_rst),
    .host_wr    (host_wr),
    .ibf_irq_en (ibf_irq_en),
    .rst_take   (rst_take),
    .host_take  (host_take),
    .host_act   (host_act)
  );

  psq_settle_timer #(.SETTLE_W(SETTLE_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .load_val  (settle_cycles),
    .tick      (tmr_tick),
    .load_zero (load_zero),
    .done      (tmr_done)
  );

  psq_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .rst_take    (rst_take),
    .host_take   (host_take),
    .host_act    (host_act),
    .load_zero   (load_zero),
    .tmr_done    (tmr_done),
    .state       (state),
    .tmr_load    (tmr_load),
    .tmr_tick    (tmr_tick),
    .exec_clk_en (exec_clk_en),
    .tmr_clk_en  (tmr_clk_en),
    .osc_en      (osc_en),
    .act         (act)
  );

  assign act_valid = (act != ACT_NONE);
  assign act_code  = act;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_rst,
  input logic       exec_clk_en,
  input logic       tmr_clk_en,
  input logic       osc_en,
  input logic       act_valid,
  input logic [1:0] act_code
);

  // R3
  osc_off_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!exec_clk_en && !tmr_clk_en));

  // R5
  pulse_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> exec_clk_en);

  // R6
  resume_has_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_clk_en) |-> act_valid);

  // R8
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (!act_valid && !exec_clk_en && osc_en && tmr_clk_en));

  // R9
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(core_rst) && !core_rst) |=> (act_valid && act_code == 2'd3));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> !act_valid);

  // R10
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |-> (act_code == 2'd0));

endmodule

bind sleep_ctrl sleep_ctrl_chk i_sleep_ctrl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_rst    (core_rst),
  .exec_clk_en (exec_clk_en),
  .tmr_clk_en  (tmr_clk_en),
  .osc_en      (osc_en),
  .act_valid   (act_valid),
  .act_code    (act_code)
);

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0, stop_req = 1'b0, host_wr = 1'b0;
  logic       ibf_irq_en = 1'b0, core_rst = 1'b0;
  logic [7:0] settle_cycles = 8'd0;
  logic       exec_clk_en, tmr_clk_en, osc_en, act_valid;
  logic [1:0] act_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_ctrl #(.SETTLE_W(8)) i_sleep_ctrl (
    .clk (clk), .rst_n (rst_n), .halt_req (halt_req), .stop_req (stop_req),
    .host_wr (host_wr), .ibf_irq_en (ibf_irq_en), .core_rst (core_rst),
    .settle_cycles (settle_cycles), .exec_clk_en (exec_clk_en),
    .tmr_clk_en (tmr_clk_en), .osc_en (osc_en), .act_valid (act_valid),
    .act_code (act_code)
  );

  // vector: [15] deep sleep, [14] ibf_irq_en, [13:12] expected code, [7:0] settle
  localparam logic [15:0] VECS [6] = '{
    16'h5000, 16'h2000, 16'hD000, 16'hA001, 16'hD005, 16'hA00C
  };

  task automatic step();
    @(negedge clk);
  endtask

  // compares {exec, tmr, osc, valid, code[1:0]}
  task automatic expect_out(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {exec_clk_en, tmr_clk_en, osc_en, act_valid, act_code};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b (exec,tmr,osc,valid,code)", req, got, exp);
    end
  endtask

  task automatic enter_sleep(input bit deep);
    if (deep) stop_req = 1'b1; else halt_req = 1'b1;
    step();
    stop_req = 1'b0; halt_req = 1'b0;
  endtask

  task automatic run_vec(input logic [15:0] v);
    bit deep;
    int n;
    deep = v[15];
    n = int'(v[7:0]);
    settle_cycles = v[7:0];
    enter_sleep(deep);
    if (deep) expect_out("R3 deep entry", 6'b000000);
    else      expect_out("R2 light entry", 6'b011000);
    step();
    if (deep) expect_out("R3 deep holds", 6'b000000);
    else      expect_out("R2 light holds", 6'b011000);
    ibf_irq_en = v[14];
    host_wr = 1'b1;
    step();
    host_wr = 1'b0;
    ibf_irq_en = ~v[14]; // later changes must not alter the chosen code
    for (int i = 0; i < n; i++) begin
      expect_out("R6 settling", 6'b001000);
      step();
    end
    if (deep) expect_out("R6 deep wake action", {4'b1111, v[13:12]});
    else      expect_out("R5 light wake action", {4'b1111, v[13:12]});
    step();
    expect_out("R10 pulse ends", 6'b111000);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_out("R1 reset state", 6'b111000);

    for (int k = 0; k < 6; k++) run_vec(VECS[k]);

    // R7: host write while running
    host_wr = 1'b1; ibf_irq_en = 1'b1;
    step();
    host_wr = 1'b0;
    expect_out("R7 write while running", 6'b111000);

    // R3: stop and halt together pick deep sleep
    stop_req = 1'b1; halt_req = 1'b1;
    step();
    stop_req = 1'b0; halt_req = 1'b0;
    expect_out("R3 stop beats halt", 6'b000000);

    // R8: reset and host write in the same cycle
    core_rst = 1'b1; host_wr = 1'b1;
    step();
    host_wr = 1'b0;
    expect_out("R8 reset over host write", 6'b011000);
    halt_req = 1'b1;
    step();
    halt_req = 1'b0;
    expect_out("R8 reset held", 6'b011000);
    expect_out("R4 halt ignored in reset", 6'b011000);
    core_rst = 1'b0;
    step();
    expect_out("R9 restart action", 6'b111111);
    step();
    expect_out("R10 restart pulse ends", 6'b111000);

    // R4: stop request while in light sleep
    enter_sleep(1'b0);
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    expect_out("R4 stop ignored in light sleep", 6'b011000);
    ibf_irq_en = 1'b0; host_wr = 1'b1;
    step();
    host_wr = 1'b0;
    expect_out("R5 continue after light sleep", 6'b111110);
    step();

    // R7 / R4: noise during settling
    settle_cycles = 8'd4;
    enter_sleep(1'b1);
    ibf_irq_en = 1'b1; host_wr = 1'b1;
    step();
    ibf_irq_en = 1'b0;
    expect_out("R6 settle start", 6'b001000);
    host_wr = 1'b1; halt_req = 1'b1; stop_req = 1'b1;
    step();
    host_wr = 1'b0; halt_req = 1'b0; stop_req = 1'b0;
    expect_out("R7 write during settle", 6'b001000);
    step();
    expect_out("R4 requests during settle", 6'b001000);
    step();
    expect_out("R6 settle last cycle", 6'b001000);
    step();
    expect_out("R6 settle end vector", 6'b111101);
    step();
    expect_out("R10 no repeat", 6'b111000);

    // R8: reset during deep sleep raises oscillator
    enter_sleep(1'b1);
    core_rst = 1'b1;
    step();
    core_rst = 1'b0;
    expect_out("R8 reset from deep sleep", 6'b011000);
    step();
    expect_out("R9 restart after deep", 6'b111111);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule